// File: doc/BRIEF.md
# Pipelined Maximum-and-Position Selector

The block accepts one vector of per-entry scores each cycle, one small unsigned value for every stored entry. It returns the largest score in that vector together with the position the score came from. Scores are reduced two at a time through a chain of registered levels. At every level, each surviving score carries the position it started at, so the index of the winner needs no second search. A downstream storage array uses that index to read out the entry that matched.

When the scores are single match flags and exactly one flag is set, the index is simply the number of the matching entry. When no entry scores above zero, a found output stays low and the index reads zero. A new vector can be accepted on every clock cycle. Each result leaves the block a fixed number of cycles after its vector entered, along with an output valid strobe.

Top module: `amx_tree`

## Requirements
- R1: When `out_valid` is high, `out_val` equals the largest of the N_IN scores in the vector that was presented with `in_valid` high DEPTH = ceil(log2 N_IN) cycles earlier (DEPTH = 6 for the default N_IN = 64). Score j occupies bits `in_vals[j*VAL_W +: VAL_W]` and is read as an unsigned number.
- R2: When `out_valid` is high, `out_idx` names a position j whose score in that same vector equals `out_val`.
- R3: If several positions share the largest score, `out_idx` is the lowest of those positions.
- R4: `out_valid` is high exactly DEPTH cycles after a cycle with `in_valid` high. Vectors presented on consecutive cycles each produce their own result on consecutive cycles, in order.
- R5: `out_found` is high exactly when `out_valid` is high and the reported score is nonzero.
- R6: For a vector in which every score is zero, the result has `out_found` low, `out_val` zero and `out_idx` zero.
- R7: For a vector in which exactly one position holds score 1 and all others hold 0, `out_idx` equals that position. This includes the first position (0) and the last position (N_IN-1).
- R8: While `rst` is high at a clock edge, the pipeline is cleared. After reset, `out_valid` and `out_found` are low, and a vector that was in flight when reset was applied never produces a result.
- R9: A cycle with `in_valid` low produces no result, whatever the value on `in_vals`. DEPTH cycles later, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | The score vector on `in_vals` is to be evaluated this cycle |
| in_vals | input | N_IN*VAL_W (256) | Packed scores; score j at bits j*VAL_W upward |
| out_valid | output | 1 | A result is present on the outputs this cycle |
| out_val | output | VAL_W (4) | Largest score of the vector |
| out_idx | output | IDX_W (6) | Position of the largest score, lowest on ties |
| out_found | output | 1 | Result valid and largest score nonzero |

## Verification
Two things share a clock cycle in this block: a fresh vector can be accepted while the result of an earlier vector leaves the last level. The bench streams vectors on back-to-back cycles, with one idle cycle in the middle of the stream. On each cycle it judges both the result that emerges and the valid pattern against a queue of expected results that the bench computes itself. Reset can also land while a vector is halfway down the levels. That case is provoked by raising reset two cycles after a vector enters, and it is judged by watching that no result ever appears for that vector.

// File: rtl/amx_pkg.sv
package amx_pkg;

    // number of scored entries and width of one score
    parameter int unsigned N_IN  = 64;
    parameter int unsigned VAL_W = 4;

    localparam int unsigned IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1;
    localparam int unsigned DEPTH = $clog2(N_IN);
    localparam int unsigned VEC_W = N_IN * VAL_W;

    // one surviving candidate: its score and the position it started at
    typedef struct packed {
        logic [VAL_W-1:0] val;
        logic [IDX_W-1:0] idx;
    } amx_node_t;

    // number of candidates alive after a given number of levels
    function automatic int unsigned amx_lvl_cnt(input int unsigned n, input int unsigned lvl);
        return (n + (32'd1 << lvl) - 1) >> lvl;
    endfunction

    // the upper candidate wins only on a strictly larger score,
    // so equal scores leave the lower position in place
    function automatic logic amx_upper_wins(input amx_node_t lower, input amx_node_t upper);
        return upper.val > lower.val;
    endfunction

endpackage

// File: rtl/amx_pick.sv
module amx_pick
    import amx_pkg::*;
(
    input  amx_node_t lo_i,
    input  amx_node_t hi_i,
    output amx_node_t win_o
);

    always_comb begin
        if (amx_upper_wins(lo_i, hi_i)) begin
            win_o = hi_i;
        end else begin
            win_o = lo_i;
        end
    end

endmodule

// File: rtl/amx_level.sv
module amx_level
    import amx_pkg::*;
#(
    parameter  int unsigned CNT_IN  = 2,
    localparam int unsigned CNT_OUT = (CNT_IN + 1) / 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      v_i,
    input  amx_node_t d_i [CNT_IN],
    output logic      v_o,
    output amx_node_t d_o [CNT_OUT]
);

    amx_node_t nxt [CNT_OUT];

    for (genvar j = 0; j < CNT_OUT; j++) begin : g_slot
        if (2 * j + 1 < CNT_IN) begin : g_pair
            amx_pick u_pick (
                .lo_i  (d_i[2*j]),
                .hi_i  (d_i[2*j+1]),
                .win_o (nxt[j])
            );
        end else begin : g_pass
            // odd leftover keeps its own score and position
            assign nxt[j] = d_i[2*j];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v_o <= 1'b0;
            for (int j = 0; j < CNT_OUT; j++) begin
                d_o[j] <= '0;
            end
        end else begin
            v_o <= v_i;
            for (int j = 0; j < CNT_OUT; j++) begin
                d_o[j] <= nxt[j];
            end
        end
    end

endmodule

// File: rtl/amx_tree.sv
module amx_tree
    import amx_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic [N_IN*VAL_W-1:0]  in_vals,
    output logic                   out_valid,
    output logic [VAL_W-1:0]       out_val,
    output logic [IDX_W-1:0]       out_idx,
    output logic                   out_found
);

    for (genvar l = 0; l < DEPTH; l++) begin : g_lvl
        localparam int unsigned CI = amx_lvl_cnt(N_IN, l);
        localparam int unsigned CO = amx_lvl_cnt(N_IN, l + 1);

        amx_node_t din  [CI];
        amx_node_t dout [CO];
        logic      vin;
        logic      vout;

        if (l == 0) begin : g_src
            for (genvar j = 0; j < CI; j++) begin : g_leaf
                assign din[j].val = in_vals[j*VAL_W +: VAL_W];
                assign din[j].idx = IDX_W'(j);
            end
            assign vin = in_valid;
        end else begin : g_chain
            for (genvar j = 0; j < CI; j++) begin : g_link
                assign din[j] = g_lvl[l-1].dout[j];
            end
            assign vin = g_lvl[l-1].vout;
        end

        amx_level #(.CNT_IN(CI)) u_lvl (
            .clk (clk),
            .rst (rst),
            .v_i (vin),
            .d_i (din),
            .v_o (vout),
            .d_o (dout)
        );
    end

    assign out_valid = g_lvl[DEPTH-1].vout;
    assign out_val   = g_lvl[DEPTH-1].dout[0].val;
    assign out_idx   = g_lvl[DEPTH-1].dout[0].idx;
    assign out_found = out_valid & (|out_val);

endmodule

// File: rtl/amx_tree_chk.sv
module amx_tree_chk
    import amx_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   in_valid,
    input logic [N_IN*VAL_W-1:0]  in_vals,
    input logic                   out_valid,
    input logic [VAL_W-1:0]       out_val,
    input logic [IDX_W-1:0]       out_idx,
    input logic                   out_found
);

    logic [DEPTH-1:0]  vpipe;
    logic [VEC_W-1:0]  vals_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            vpipe <= '0;
        end else begin
            vpipe <= {vpipe[DEPTH-2:0], in_valid};
        end
        vals_q[0] <= in_vals;
        for (int d = 1; d < DEPTH; d++) begin
            vals_q[d] <= vals_q[d-1];
        end
    end

    function automatic logic [VAL_W-1:0] ref_max(input logic [VEC_W-1:0] v);
        logic [VAL_W-1:0] m;
        m = '0;
        for (int j = 0; j < N_IN; j++) begin
            if (v[j*VAL_W +: VAL_W] > m) m = v[j*VAL_W +: VAL_W];
        end
        return m;
    endfunction

    function automatic logic [IDX_W-1:0] ref_first(input logic [VEC_W-1:0] v,
                                                   input logic [VAL_W-1:0] t);
        logic [IDX_W-1:0] r;
        logic             hit;
        r   = '0;
        hit = 1'b0;
        for (int j = 0; j < N_IN; j++) begin
            if (!hit && v[j*VAL_W +: VAL_W] == t) begin
                r   = IDX_W'(j);
                hit = 1'b1;
            end
        end
        return r;
    endfunction

    logic [VEC_W-1:0] vals_last;
    assign vals_last = vals_q[DEPTH-1];

    a_r4_valid_latency: assert property (@(posedge clk) disable iff (rst)
        out_valid == vpipe[DEPTH-1]);

    a_r1_max_value: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_val == ref_max(vals_last));

    a_r2_idx_points_at_val: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> vals_last[out_idx*VAL_W +: VAL_W] == out_val);

    a_r3_lowest_on_tie: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_idx == ref_first(vals_last, out_val));

    a_r5_found_from_inputs: assert property (@(posedge clk) disable iff (rst)
        out_found == (vpipe[DEPTH-1] && (|vals_last)));

    a_r6_zero_idx: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_found) |-> (out_idx == '0 && out_val == '0));

    a_r8_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!out_valid && !out_found));

endmodule

bind amx_tree amx_tree_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_vals   (in_vals),
    .out_valid (out_valid),
    .out_val   (out_val),
    .out_idx   (out_idx),
    .out_found (out_found)
);

// File: tb/sim_amx_tree.sv
module sim_amx_tree;
    import amx_pkg::*;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  in_valid = 1'b0;
    logic [VEC_W-1:0]      in_vals = '0;
    logic                  out_valid;
    logic [VAL_W-1:0]      out_val;
    logic [IDX_W-1:0]      out_idx;
    logic                  out_found;

    int n_chk = 0;
    int n_err = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #4 clk = ~clk;

    amx_tree u0 (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_vals   (in_vals),
        .out_valid (out_valid),
        .out_val   (out_val),
        .out_idx   (out_idx),
        .out_found (out_found)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] nxt_rand(input logic [31:0] s);
        logic [31:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    // expected winner: strict comparison keeps the lowest position
    task automatic expect_of(input logic [VEC_W-1:0] v, output int mx, output int ix);
        mx = 0;
        ix = 0;
        for (int j = 0; j < N_IN; j++) begin
            if (int'(v[j*VAL_W +: VAL_W]) > mx) begin
                mx = int'(v[j*VAL_W +: VAL_W]);
                ix = j;
            end
        end
    endtask

    task automatic rand_vec(output logic [VEC_W-1:0] v);
        for (int j = 0; j < N_IN; j++) begin
            seed = nxt_rand(seed);
            v[j*VAL_W +: VAL_W] = seed[VAL_W+3:4];
        end
    endtask

    // one vector in, result checked DEPTH cycles later
    task automatic t_single(input logic [VEC_W-1:0] v, input string tag);
        int mx, ix;
        expect_of(v, mx, ix);
        @(negedge clk);
        in_vals  = v;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        in_vals  = '1;
        repeat (DEPTH - 1) @(negedge clk);
        chk({tag, " R4 valid"}, int'(out_valid), 1);
        chk({tag, " R1 value"}, int'(out_val), mx);
        chk({tag, " R2/R3 index"}, int'(out_idx), ix);
        chk({tag, " R5 found"}, int'(out_found), (mx != 0) ? 1 : 0);
        @(negedge clk);
        chk({tag, " R9 no extra result"}, int'(out_valid), 0);
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        chk("R8 valid in reset", int'(out_valid), 0);
        chk("R8 found in reset", int'(out_found), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R8 valid after reset", int'(out_valid), 0);
    endtask

    task automatic t_onehot();
        logic [VEC_W-1:0] v;
        int pos [3] = '{0, 37, N_IN - 1};
        foreach (pos[p]) begin
            v = '0;
            v[pos[p]*VAL_W +: VAL_W] = VAL_W'(1);
            t_single(v, $sformatf("R7 onehot@%0d", pos[p]));
        end
    endtask

    task automatic t_zero();
        t_single('0, "R6 all zero");
    endtask

    task automatic t_ties();
        logic [VEC_W-1:0] v;
        v = '0;
        for (int j = 0; j < N_IN; j++) v[j*VAL_W +: VAL_W] = VAL_W'(7);
        t_single(v, "R3 all equal");
        v = '0;
        v[5*VAL_W +: VAL_W]  = VAL_W'(9);
        v[40*VAL_W +: VAL_W] = VAL_W'(9);
        v[2*VAL_W +: VAL_W]  = VAL_W'(8);
        t_single(v, "R3 tie 5 vs 40");
        v = '0;
        v[(N_IN-1)*VAL_W +: VAL_W] = '1;
        v[0 +: VAL_W] = VAL_W'(14);
        t_single(v, "R1 max at top");
    endtask

    task automatic t_gap_ignored();
        @(negedge clk);
        in_valid = 1'b0;
        in_vals  = '1;
        repeat (DEPTH + 1) @(negedge clk);
        chk("R9 idle data ignored valid", int'(out_valid), 0);
        chk("R9 idle data ignored found", int'(out_found), 0);
    endtask

    // back-to-back vectors with one idle slot in the middle
    task automatic t_stream();
        localparam int NV = 12;
        logic [VEC_W-1:0] vecs [NV];
        logic             vld  [NV];
        int mx, ix;
        for (int k = 0; k < NV; k++) begin
            rand_vec(vecs[k]);
            vld[k] = (k != 5);
        end
        for (int c = 0; c < NV + DEPTH + 1; c++) begin
            @(negedge clk);
            if (c >= DEPTH && c - DEPTH < NV) begin
                chk($sformatf("R4 stream valid c%0d", c), int'(out_valid),
                    vld[c-DEPTH] ? 1 : 0);
                if (vld[c-DEPTH]) begin
                    expect_of(vecs[c-DEPTH], mx, ix);
                    chk($sformatf("R1 stream val c%0d", c), int'(out_val), mx);
                    chk($sformatf("R3 stream idx c%0d", c), int'(out_idx), ix);
                end
            end else begin
                chk($sformatf("R4 stream idle c%0d", c), int'(out_valid), 0);
            end
            if (c < NV) begin
                in_vals  = vecs[c];
                in_valid = vld[c];
            end else begin
                in_valid = 1'b0;
            end
        end
    endtask

    task automatic t_reset_flush();
        logic [VEC_W-1:0] v;
        rand_vec(v);
        @(negedge clk);
        in_vals  = v;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int c = 0; c < DEPTH + 2; c++) begin
            @(negedge clk);
            chk("R8 flushed vector", int'(out_valid), 0);
        end
    endtask

    initial begin
        #(8 * 150000);
        n_err++;
        $display("FAIL watchdog R4 actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [VEC_W-1:0] v;
        t_reset_state();
        t_zero();
        t_onehot();
        t_ties();
        for (int k = 0; k < 4; k++) begin
            rand_vec(v);
            t_single(v, $sformatf("R1 random %0d", k));
        end
        t_gap_ignored();
        t_stream();
        t_reset_flush();
        t_single('0, "R6 zero after flush");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule